// File: doc/BRIEF.md
# Encoder Input Conditioning Filter

This block prepares the four raw signals of an incremental encoder for a quadrature decoder: the two phase channels, the index pulse and the home switch. Every pin is first brought into the clock domain through a two-stage synchronizer. After that, a per-pin inversion is applied, and the two phase channels can be exchanged. A glitch filter can then be switched into the path; it samples at a rate set by a power-of-two prescaler.

The block drives two sets of outputs. The first is the four conditioned signals that go to the decoder. The second is a 4-bit level vector that shows each input after inversion and swapping. The level vector never passes through the glitch filter, so software or a neighbouring block can watch the pins without waiting for the filter.

There is no data stream at the edges of this block. Every port is a level that is sampled on each clock, so there is no valid/ready handshake and no back-pressure. Control inputs take effect on the next clock edge.

Top module: `enc_cond_top`

## Requirements
- R1: During reset, with all pins low and all controls at 0, every conditioned output and every level bit reads 0.
- R2: Each pin has its own inversion bit, `pol_inv[0]` for phase A, `[1]` for phase B, `[2]` for index and `[3]` for home. A 1 inverts that pin and a 0 passes it unchanged.
- R3: When `swap_ab` is 1, the two phase channels are exchanged after inversion. Each inversion bit stays tied to its physical pin.
- R4: `lvl_stat` holds the conditioned levels at fixed positions: bit 0 phase A, bit 1 phase B, bit 2 index, bit 3 home. These bits never pass through the glitch filter.
- R5: A pin change shows on `lvl_stat` on the second rising clock edge, counting the edge that first captures it.
- R6: With `filt_en` at 0, each conditioned output equals its `lvl_stat` bit.
- R7: With `filt_en` at 1 and `div_sel` at 0, an output takes a new level only after three consecutive samples agree. A steady change appears on the fifth edge after capture. A pulse of two cycles is rejected, and a pulse of three cycles passes.
- R8: `div_sel` = s produces one sample every 2^s cycles. A steady change therefore appears between edge 3+2D and edge 2+3D, where D = 2^s. A pulse of 6 cycles is rejected at D = 4.
- R9: A change of `div_sel` restarts the prescaler. If the new value is applied in the same cycle that a pin change is captured, the output follows on exactly edge 3D+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Raw phase A pin |
| enc_b | input | 1 | Raw phase B pin |
| enc_idx | input | 1 | Raw index pin |
| enc_home | input | 1 | Raw home pin |
| pol_inv | input | 4 | Per-pin inversion (bit 0 A, 1 B, 2 index, 3 home) |
| swap_ab | input | 1 | Exchange phase A and phase B |
| filt_en | input | 1 | Route outputs through the glitch filter |
| div_sel | input | 3 | Filter sample rate: one sample per 2^div_sel cycles |
| q_a | output | 1 | Conditioned phase A |
| q_b | output | 1 | Conditioned phase B |
| q_idx | output | 1 | Conditioned index |
| q_home | output | 1 | Conditioned home |
| lvl_stat | output | 4 | Levels after inversion and swap, unfiltered |

## Verification
A prescaler restart and a pin edge entering the filter can land in the same cycle. The bench provokes this by writing a new `div_sel` on the same falling edge that toggles a pin. It then counts edges until the filtered output moves. It accepts only the exact count 3D+1, because a prescaler that kept its old phase would give any value across the wider window of R8. The same run also checks that `lvl_stat` has already moved while the filtered output still holds its old level.

// File: rtl/enc_cond_pkg.sv
package enc_cond_pkg;
  localparam int LANES      = 4;
  localparam int LANE_A     = 0;
  localparam int LANE_B     = 1;
  localparam int LANE_IDX   = 2;
  localparam int LANE_HOME  = 3;
  localparam int SYNC_DEPTH = 2;
  localparam int AGREE_N    = 3;
  localparam int SEL_W      = 3;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/enc_pol_swap.sv
module enc_pol_swap
  import enc_cond_pkg::*;
(
  input  logic [LANES-1:0] raw,
  input  logic [LANES-1:0] inv,
  input  logic             swap,
  output logic [LANES-1:0] cond
);
  logic [LANES-1:0] flipped;

  always_comb begin
    flipped = raw ^ inv;
    cond    = flipped;
    if (swap) begin
      cond[LANE_A] = flipped[LANE_B];
      cond[LANE_B] = flipped[LANE_A];
    end
  end
endmodule

// File: rtl/enc_prescaler.sv
module enc_prescaler #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int CNT_W = (1 << SW) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [SW-1:0]    sel_q;
  logic             restart;

  always_comb begin
    lim     = ~({CNT_W{1'b1}} << sel);
    restart = (sel != sel_q);
    tick    = !restart && (cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      if (restart || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter #(
  parameter int AGREE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic d,
  output logic q
);
  localparam int HW = AGREE - 1;

  logic [HW-1:0] hist;
  logic          agree;
  logic [HW-1:0] hist_nx;

  assign agree = (hist == {HW{d}});

  if (HW == 1) begin : g_short
    assign hist_nx = d;
  end else begin : g_long
    assign hist_nx = {hist[HW-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      q    <= 1'b0;
    end else if (tick) begin
      hist <= hist_nx;
      if (agree) q <= d;
    end
  end
endmodule

// File: rtl/enc_cond_top.sv
module enc_cond_top
  import enc_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             enc_home,
  input  logic [LANES-1:0] pol_inv,
  input  logic             swap_ab,
  input  logic             filt_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             q_a,
  output logic             q_b,
  output logic             q_idx,
  output logic             q_home,
  output logic [LANES-1:0] lvl_stat
);
  logic [LANES-1:0] raw_pins;
  logic [LANES-1:0] synced;
  logic [LANES-1:0] cond;
  logic [LANES-1:0] filtered;
  logic [LANES-1:0] q_vec;
  logic             smp_tick;

  always_comb begin
    raw_pins            = '0;
    raw_pins[LANE_A]    = enc_a;
    raw_pins[LANE_B]    = enc_b;
    raw_pins[LANE_IDX]  = enc_idx;
    raw_pins[LANE_HOME] = enc_home;
  end

  enc_sync #(.W(LANES), .STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(synced)
  );

  enc_pol_swap polsw_i (
    .raw(synced), .inv(pol_inv), .swap(swap_ab), .cond(cond)
  );

  enc_prescaler #(.SW(SEL_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(smp_tick)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    enc_glitch_filter #(.AGREE(AGREE_N)) filt_i (
      .clk(clk), .rst_n(rst_n), .tick(smp_tick),
      .d(cond[i]), .q(filtered[i])
    );
  end

  assign q_vec    = filt_en ? filtered : cond;
  assign lvl_stat = cond;
  assign q_a      = q_vec[LANE_A];
  assign q_b      = q_vec[LANE_B];
  assign q_idx    = q_vec[LANE_IDX];
  assign q_home   = q_vec[LANE_HOME];
endmodule

// File: rtl/enc_cond_chk.sv
module enc_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_a,
  input logic       enc_b,
  input logic       enc_idx,
  input logic       enc_home,
  input logic [3:0] pol_inv,
  input logic       swap_ab,
  input logic       filt_en,
  input logic       q_a,
  input logic       q_b,
  input logic       q_idx,
  input logic       q_home,
  input logic [3:0] lvl_stat
);
  logic [1:0] warm_cnt;
  logic       warm;
  logic [3:0] outs;

  assign outs = {q_home, q_idx, q_b, q_a};
  assign warm = (warm_cnt == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 1'b1;
  end

  // R3 and R5: phase bits follow the pins two edges late, after inversion and swap
  assert_status_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (lvl_stat[0] == (swap_ab ? ($past(enc_b, 2) ^ pol_inv[1])
                                      : ($past(enc_a, 2) ^ pol_inv[0]))) &&
             (lvl_stat[1] == (swap_ab ? ($past(enc_a, 2) ^ pol_inv[0])
                                      : ($past(enc_b, 2) ^ pol_inv[1]))));

  // R2: index and home bits follow their pins with their own inversion
  assert_status_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (lvl_stat[2] == ($past(enc_idx, 2) ^ pol_inv[2])) &&
             (lvl_stat[3] == ($past(enc_home, 2) ^ pol_inv[3])));

  // R6: bypassed outputs equal the level vector
  assert_bypass_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> (outs == lvl_stat));

  // R7: a filtered output only moves to a level seen for the preceding cycles
  for (genvar i = 0; i < 4; i++) begin : g_agree
    assert_filter_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_en && $past(filt_en) && (outs[i] != $past(outs[i]))) |->
        (($past(lvl_stat[i]) == outs[i]) && ($past(lvl_stat[i], 2) == outs[i])));
  end
endmodule

bind enc_cond_top enc_cond_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
  .enc_idx(enc_idx), .enc_home(enc_home), .pol_inv(pol_inv),
  .swap_ab(swap_ab), .filt_en(filt_en), .q_a(q_a), .q_b(q_b),
  .q_idx(q_idx), .q_home(q_home), .lvl_stat(lvl_stat)
);

// File: tb/enc_cond_top_tb_top.sv
`timescale 1ns/1ps
module enc_cond_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, enc_home = 1'b0;
  logic [3:0] pol_inv = '0;
  logic       swap_ab = 1'b0;
  logic       filt_en = 1'b0;
  logic [2:0] div_sel = '0;
  logic       q_a, q_b, q_idx, q_home;
  logic [3:0] lvl_stat;
  logic [3:0] q_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign q_vec = {q_home, q_idx, q_b, q_a};

  enc_cond_top dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .enc_home(enc_home), .pol_inv(pol_inv),
    .swap_ab(swap_ab), .filt_en(filt_en), .div_sel(div_sel),
    .q_a(q_a), .q_b(q_b), .q_idx(q_idx), .q_home(q_home),
    .lvl_stat(lvl_stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // edges counted from the first edge that captures the change; -1 if none
  task automatic measure(input int lane, input logic tgt, input int lim, output int n);
    n = -1;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (q_vec[lane] === tgt) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check({q_vec, lvl_stat} == 8'h00, "R1 outputs in reset", {q_vec, lvl_stat}, 0);
    rst_n = 1'b1;
    idle(4);
    check({q_vec, lvl_stat} == 8'h00, "R1 outputs after reset", {q_vec, lvl_stat}, 0);
  endtask

  task automatic t_polarity;
    filt_en = 1'b0; swap_ab = 1'b0;
    {enc_home, enc_idx, enc_b, enc_a} = 4'b0101;
    pol_inv = 4'b0011;
    idle(3);
    check(lvl_stat == 4'b0110, "R2 inversion pattern 1", lvl_stat, 4'b0110);
    check(q_vec == 4'b0110, "R6 bypass outputs pattern 1", q_vec, 4'b0110);
    {enc_home, enc_idx, enc_b, enc_a} = 4'b0000;
    pol_inv = 4'b1100;
    idle(3);
    check(lvl_stat == 4'b1100, "R4 bit positions pattern 2", lvl_stat, 4'b1100);
    pol_inv = 4'b0000;
    idle(3);
  endtask

  task automatic t_swap;
    filt_en = 1'b0;
    {enc_home, enc_idx, enc_b, enc_a} = 4'b0011;
    pol_inv = 4'b0001;
    swap_ab = 1'b0;
    idle(3);
    check(lvl_stat[1:0] == 2'b10, "R3 no swap", lvl_stat[1:0], 2);
    swap_ab = 1'b1;
    @(negedge clk);
    check(lvl_stat[1:0] == 2'b01, "R3 swap keeps inversion on pin", lvl_stat[1:0], 1);
    check(q_vec[1:0] == 2'b01, "R3 swapped outputs", q_vec[1:0], 1);
    swap_ab = 1'b0; pol_inv = '0;
    {enc_home, enc_idx, enc_b, enc_a} = 4'b0000;
    idle(4);
  endtask

  task automatic t_bypass_latency;
    int n;
    filt_en = 1'b0;
    enc_idx = 1'b1;
    measure(2, 1'b1, 10, n);
    check(n == 2, "R5 status lag edges", n, 2);
    check(lvl_stat[2] == 1'b1, "R6 bypass index follows", lvl_stat[2], 1);
    enc_idx = 1'b0;
    idle(4);
  endtask

  task automatic t_filter_div1;
    int n;
    filt_en = 1'b1; div_sel = 3'd0;
    idle(6);
    enc_a = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(lvl_stat[0] == 1'b1 && q_a == 1'b0, "R4 status ahead of filter",
          {lvl_stat[0], q_a}, 2);
    measure(0, 1'b1, 20, n);
    check(n == 3, "R7 steady change on fifth edge", n + 2, 5);
    enc_a = 1'b0;
    idle(8);
  endtask

  task automatic t_glitch;
    bit seen;
    filt_en = 1'b1; div_sel = 3'd0;
    idle(6);
    enc_b = 1'b1; idle(2); enc_b = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (q_b) seen = 1'b1;
    end
    check(!seen, "R7 two-cycle pulse rejected", seen, 0);
    enc_b = 1'b1; idle(3); enc_b = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (q_b) seen = 1'b1;
    end
    check(seen, "R7 three-cycle pulse passes", seen, 1);
    idle(6);
  endtask

  task automatic t_divide;
    int n;
    bit dropped;
    filt_en = 1'b1; div_sel = 3'd2;
    idle(40);
    enc_home = 1'b1;
    measure(3, 1'b1, 40, n);
    check(n >= 11 && n <= 14, "R8 div4 latency window", n, 11);
    idle(40);
    enc_home = 1'b0; idle(6); enc_home = 1'b1;
    dropped = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!q_home) dropped = 1'b1;
    end
    check(!dropped, "R8 six-cycle pulse rejected at div4", dropped, 0);
    div_sel = 3'd3;
    idle(60);
    enc_home = 1'b0;
    measure(3, 1'b0, 60, n);
    check(n >= 19 && n <= 26, "R8 div8 latency window", n, 19);
    idle(60);
  endtask

  task automatic t_restart;
    int n;
    filt_en = 1'b1; div_sel = 3'd0;
    idle(20);
    div_sel = 3'd2; enc_a = 1'b1;
    measure(0, 1'b1, 40, n);
    check(n == 13, "R9 restart div4 exact", n, 13);
    idle(40);
    div_sel = 3'd3; enc_a = 1'b0;
    measure(0, 1'b0, 60, n);
    check(n == 25, "R9 restart div8 exact", n, 25);
    div_sel = 3'd0;
    idle(10);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    t_polarity();
    t_swap();
    t_bypass_latency();
    t_filter_div1();
    t_glitch();
    t_divide();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule